// File: doc/BRIEF.md
# Low-Power Wakeup Event Controller

This block gathers wakeup events for a chip that sleeps in a low-power mode. It watches two GPIO ports of up to 32 pins each, plus a handful of low-power peripheral sources: two timers, a low-power UART, two analog comparators and a backup-mode wake line. Every source has a sticky pending flag. Software clears a flag by writing a one to it. The block ORs every pending flag that is enabled into a single registered wakeup interrupt.

A GPIO flag is set when the synchronized pin changes level in either direction. A GPIO flag can only raise the interrupt when two conditions hold: the chip-level GPIO wakeup enable input is high, and the pin's own enable bit is set. The peripheral status word holds two kinds of bit. Some are write-one-to-clear flags. The others are read-only bits that show the live comparator outputs.

Software reaches the registers over a simple bus. The address is a byte offset, and there are separate read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After reset, every status and enable register reads 0 and `wake_irq_o` is low.
- R2: Each GPIO pin goes through a two-flop synchronizer. Any level change on the pin, rising or falling, sets the pin's bit in its port status register (port 0 at offset 0x04, port 1 at 0x0C; bit n is pin n).
- R3: Status flags are sticky. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: A GPIO flag drives the interrupt only when `gpio_wake_en_i` is high and the matching bit in the port enable register is set (port 0 at 0x08, port 1 at 0x10).
- R5: A one-cycle pulse on `periph_evt_i` sets a flag in the peripheral status register at 0x30. The mapping from input index to status bit is: input 0 (timer 0) to bit 0, input 1 (timer 1) to bit 1, input 2 (UART) to bit 2, input 3 (comparator 0) to bit 3, input 4 (comparator 1) to bit 4, and input 5 (backup wake) to bit 16.
- R6: Bits 5 and 6 of the peripheral status register read back the live values of `cmp_level_i[0]` and `cmp_level_i[1]`. Writes to these bits have no effect.
- R7: The peripheral enable register at 0x34 keeps only bits 0 to 4, one per interrupting source, in the same order as status bits 0 to 4. All its other bits read 0.
- R8: If an event and a write-one-to-clear reach the same flag in the same cycle, the flag stays set.
- R9: `wake_irq_o` is the OR of all enabled pending flags, registered for one cycle. It falls once those flags are cleared. The backup-wake flag never drives it.
- R10: Reads from an unmapped offset return 0. Writes to an unmapped offset change no register.
- R11: `reg_rdata_o` updates on the clock edge where `reg_rd_i` is high, and it holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio0_i | input | PIN_W | GPIO port 0 pins (asynchronous) |
| gpio1_i | input | PIN_W | GPIO port 1 pins (asynchronous) |
| gpio_wake_en_i | input | 1 | Chip-level GPIO wakeup enable |
| periph_evt_i | input | 6 | Peripheral event pulses, synchronous to clk |
| cmp_level_i | input | 2 | Live comparator outputs |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | DATA_W | Registered read data |
| wake_irq_o | output | 1 | Wakeup interrupt |

## Verification
The bench drives falling edges as well as rising ones. A design that detects only one direction would leave the status bit at zero after the falling edge. It writes masks that mix zeros and ones, so a design that loads status from the write data, instead of clearing only the written ones, loses flags that should stay set. It lines up a timer pulse with a clear of the same bit, which catches a design where the clear takes priority. It then toggles the chip-level GPIO enable, writes all ones to the read-only comparator bits, to the enable bits that do not exist, and to unmapped offsets, and checks that the backup flag alone keeps the interrupt low. A design with a leaky gate, a writable live bit, or a broken address decode would show up as a wrong readback or a stray interrupt.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int ADDR_W      = 8;
   localparam int DATA_W      = 32;
   localparam int PEV_N       = 6;
   localparam int PEN_N       = 5;
   localparam int CMP_N       = 2;

   localparam logic [ADDR_W-1:0] OFF_P0_ST = 8'h04;
   localparam logic [ADDR_W-1:0] OFF_P0_EN = 8'h08;
   localparam logic [ADDR_W-1:0] OFF_P1_ST = 8'h0C;
   localparam logic [ADDR_W-1:0] OFF_P1_EN = 8'h10;
   localparam logic [ADDR_W-1:0] OFF_PV_ST = 8'h30;
   localparam logic [ADDR_W-1:0] OFF_PV_EN = 8'h34;

   localparam int CMP_BIT0 = 5;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_P0_ST, SEL_P0_EN, SEL_P1_ST, SEL_P1_EN, SEL_PV_ST, SEL_PV_EN
   } reg_sel_e;

   // status bit position of peripheral event index i
   function automatic int pev_pos(input int i);
      return (i == PEV_N - 1) ? 16 : i;
   endfunction

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      case (a)
         OFF_P0_ST: return SEL_P0_ST;
         OFF_P0_EN: return SEL_P0_EN;
         OFF_P1_ST: return SEL_P1_ST;
         OFF_P1_EN: return SEL_P1_EN;
         OFF_PV_ST: return SEL_PV_ST;
         OFF_PV_EN: return SEL_PV_EN;
         default:   return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/wake_sync_edge.sv
module wake_sync_edge #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] edge_o
);
   if (STAGES < 2) begin : g_bad
      $error("wake_sync_edge: STAGES must be at least 2");
   end
   if (W < 1) begin : g_badw
      $error("wake_sync_edge: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];
   logic [W-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign edge_o = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wake_flag_bank.sv
module wake_flag_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flags_o
);
   if (W < 1) begin : g_bad
      $error("wake_flag_bank: W must be positive");
   end

   logic [W-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;   // set wins
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/wake_enable_reg.sv
module wake_enable_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (we_i) q <= d_i;
   end

   assign q_o = q;
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
   import wake_pkg::*;
#(
   parameter int PIN_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  gpio0_i,
   input  logic [PIN_W-1:0]  gpio1_i,
   input  logic              gpio_wake_en_i,
   input  logic [PEV_N-1:0]  periph_evt_i,
   input  logic [CMP_N-1:0]  cmp_level_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   input  logic              reg_rd_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              wake_irq_o
);
   localparam int NPORT = 2;

   if (PIN_W < 1 || PIN_W > DATA_W) begin : g_bad_pin
      $error("wake_evt_ctrl: PIN_W must lie in 1..DATA_W");
   end

   // ---------------- decode ----------------
   reg_sel_e sel;
   assign sel = decode(reg_addr_i);

   logic [PIN_W-1:0] pin_in  [NPORT];
   logic [PIN_W-1:0] pin_edge[NPORT];
   logic [PIN_W-1:0] gst     [NPORT];
   logic [PIN_W-1:0] gen     [NPORT];
   logic [PIN_W-1:0] gclr    [NPORT];
   logic             gen_we  [NPORT];
   logic [NPORT-1:0] gpend;

   assign pin_in[0] = gpio0_i;
   assign pin_in[1] = gpio1_i;
   assign gclr[0]   = (reg_wr_i && sel == SEL_P0_ST) ? reg_wdata_i[PIN_W-1:0] : '0;
   assign gclr[1]   = (reg_wr_i && sel == SEL_P1_ST) ? reg_wdata_i[PIN_W-1:0] : '0;
   assign gen_we[0] = reg_wr_i && sel == SEL_P0_EN;
   assign gen_we[1] = reg_wr_i && sel == SEL_P1_EN;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      wake_sync_edge #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (pin_in[p]),
         .edge_o  (pin_edge[p])
      );
      wake_flag_bank #(.W(PIN_W)) u_flags (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (pin_edge[p]),
         .clr_i   (gclr[p]),
         .flags_o (gst[p])
      );
      wake_enable_reg #(.W(PIN_W)) u_en (
         .clk   (clk),
         .rst_n (rst_n),
         .we_i  (gen_we[p]),
         .d_i   (reg_wdata_i[PIN_W-1:0]),
         .q_o   (gen[p])
      );
      assign gpend[p] = |(gst[p] & gen[p]);
   end

   // ---------------- peripheral sources ----------------
   logic [PEV_N-1:0] pclr;
   logic [PEV_N-1:0] pst;
   logic [PEN_N-1:0] pen;
   logic             pen_we;

   for (genvar i = 0; i < PEV_N; i++) begin : g_pclr
      assign pclr[i] = reg_wr_i && sel == SEL_PV_ST && reg_wdata_i[pev_pos(i)];
   end

   wake_flag_bank #(.W(PEV_N)) u_pflags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (periph_evt_i),
      .clr_i   (pclr),
      .flags_o (pst)
   );

   assign pen_we = reg_wr_i && sel == SEL_PV_EN;

   wake_enable_reg #(.W(PEN_N)) u_pen (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (pen_we),
      .d_i   (reg_wdata_i[PEN_N-1:0]),
      .q_o   (pen)
   );

   // ---------------- read path ----------------
   logic [DATA_W-1:0] pst_word;
   always_comb begin
      pst_word = '0;
      for (int i = 0; i < PEV_N; i++) pst_word[pev_pos(i)] = pst[i];
      for (int c = 0; c < CMP_N; c++) pst_word[CMP_BIT0 + c] = cmp_level_i[c];
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_P0_ST: rd_mux[PIN_W-1:0] = gst[0];
         SEL_P0_EN: rd_mux[PIN_W-1:0] = gen[0];
         SEL_P1_ST: rd_mux[PIN_W-1:0] = gst[1];
         SEL_P1_EN: rd_mux[PIN_W-1:0] = gen[1];
         SEL_PV_ST: rd_mux = pst_word;
         SEL_PV_EN: rd_mux[PEN_N-1:0] = pen;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        reg_rdata_o <= '0;
      else if (reg_rd_i) reg_rdata_o <= rd_mux;
   end

   // ---------------- interrupt ----------------
   logic irq_d;
   assign irq_d = (gpio_wake_en_i && (|gpend)) || (|(pst[PEN_N-1:0] & pen));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_irq_o <= 1'b0;
      else        wake_irq_o <= irq_d;
   end

   // flat copies for the checker
   logic [PIN_W-1:0] st0_w, st1_w, en0_w, en1_w;
   assign st0_w = gst[0];
   assign st1_w = gst[1];
   assign en0_w = gen[0];
   assign en1_w = gen[1];
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk
   import wake_pkg::*;
#(
   parameter int PIN_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gpio_wake_en_i,
   input logic [PEV_N-1:0]  periph_evt_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic              reg_wr_i,
   input logic              reg_rd_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              wake_irq_o,
   input logic [PIN_W-1:0]  st0,
   input logic [PIN_W-1:0]  st1,
   input logic [PEV_N-1:0]  pst,
   input logic [PEN_N-1:0]  pen
);
   logic unmapped;
   assign unmapped = (decode(reg_addr_i) == SEL_NONE);

   AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (st0 == '0 && st1 == '0 && pst == '0 && !wake_irq_o)); // R1
   AST_GPIO_STICKY0: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_i && reg_addr_i == OFF_P0_ST) |=> ((st0 & $past(st0)) == $past(st0))); // R3
   AST_GPIO_STICKY1: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_i && reg_addr_i == OFF_P1_ST) |=> ((st1 & $past(st1)) == $past(st1))); // R3
   AST_GPIO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!gpio_wake_en_i && (pst[PEN_N-1:0] & pen) == '0) |=> !wake_irq_o); // R4
   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      periph_evt_i[0] |=> pst[0]); // R8
   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && unmapped) |=> reg_rdata_o == '0); // R10
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |=> $stable(reg_rdata_o)); // R11
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .gpio_wake_en_i (gpio_wake_en_i),
   .periph_evt_i   (periph_evt_i),
   .reg_addr_i     (reg_addr_i),
   .reg_wr_i       (reg_wr_i),
   .reg_rd_i       (reg_rd_i),
   .reg_rdata_o    (reg_rdata_o),
   .wake_irq_o     (wake_irq_o),
   .st0            (st0_w),
   .st1            (st1_w),
   .pst            (pst),
   .pen            (pen)
);

// File: tb/wake_evt_ctrl_test.sv
module wake_evt_ctrl_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] gpio0 = '0, gpio1 = '0;
   logic        gwen = 0;
   logic [5:0]  pevt = '0;
   logic [1:0]  cmp = '0;
   logic [7:0]  addr = '0;
   logic        wr = 0, rd = 0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0, errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   wake_evt_ctrl uut (
      .clk(clk), .rst_n(rst_n), .gpio0_i(gpio0), .gpio1_i(gpio1),
      .gpio_wake_en_i(gwen), .periph_evt_i(pevt), .cmp_level_i(cmp),
      .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
      .reg_rd_i(rd), .reg_rdata_o(rdata), .wake_irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1;
      @(negedge clk); wr = 0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd = 1;
      @(negedge clk); rd = 0; d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq", {31'b0, irq}, 0);
      rd_reg(8'h04, v); chk("R1 p0st", v, 0);
      rd_reg(8'h10, v); chk("R1 p1en", v, 0);
      rd_reg(8'h30, v); chk("R1 pvst", v, 0);
   endtask

   task automatic t_gpio_edges();
      logic [31:0] v;
      @(negedge clk); gpio0[3] = 1; idle(4);
      rd_reg(8'h04, v); chk("R2 p0 rise", v, 32'h8);
      wr_reg(8'h04, 32'h8);
      rd_reg(8'h04, v); chk("R3 clear", v, 0);
      @(negedge clk); gpio0[3] = 0; idle(4);
      rd_reg(8'h04, v); chk("R2 p0 fall", v, 32'h8);
      @(negedge clk); gpio1[31] = 1; idle(4);
      wr_reg(8'h0C, 32'h8000_0000);
      @(negedge clk); gpio1[31] = 0; gpio1[0] = 1; idle(4);
      rd_reg(8'h0C, v); chk("R2 p1 fall+rise", v, 32'h8000_0001);
      wr_reg(8'h0C, 32'h0000_0001);
      rd_reg(8'h0C, v); chk("R3 write0 keeps", v, 32'h8000_0000);
      // idle read of R11: hold value across cycles
      idle(3); chk("R11 hold", rdata, 32'h8000_0000);
   endtask

   task automatic t_gpio_irq();
      logic [31:0] v;
      // p0 bit3 and p1 bit31 pending
      wr_reg(8'h08, 32'h8);
      idle(2); chk("R4 no global", {31'b0, irq}, 0);
      @(negedge clk); gwen = 1; idle(2);
      chk("R4 both enables", {31'b0, irq}, 1);
      wr_reg(8'h08, 32'h0); idle(2);
      chk("R4 pin disabled", {31'b0, irq}, 0);
      wr_reg(8'h10, 32'h8000_0000); idle(2);
      chk("R4 port1", {31'b0, irq}, 1);
      wr_reg(8'h0C, 32'hFFFF_FFFF); idle(2);
      chk("R9 deassert", {31'b0, irq}, 0);
      rd_reg(8'h10, v); chk("R4 p1en readback", v, 32'h8000_0000);
      wr_reg(8'h04, 32'hFFFF_FFFF);
      @(negedge clk); gwen = 0;
   endtask

   task automatic t_periph();
      logic [31:0] v;
      @(negedge clk); pevt = 6'h3F;
      @(negedge clk); pevt = 0; cmp = 2'b10;
      rd_reg(8'h30, v); chk("R5/R6 positions", v, 32'h0001_005F);
      wr_reg(8'h30, 32'hFFFF_FFE0);
      rd_reg(8'h30, v); chk("R6 ro + R5 clear16", v, 32'h0000_005F);
      wr_reg(8'h34, 32'hFFFF_FFFF);
      rd_reg(8'h34, v); chk("R7 pen bits", v, 32'h1F);
      idle(1); chk("R9 periph irq", {31'b0, irq}, 1);
      wr_reg(8'h30, 32'h0000_001E);
      rd_reg(8'h30, v); chk("R3 partial", v, 32'h0000_0041);
      // R8 collision: pulse and clear of bit0 same cycle
      @(negedge clk); addr = 8'h30; wdata = 32'h1; wr = 1; pevt = 6'h01;
      @(negedge clk); wr = 0; pevt = 0;
      rd_reg(8'h30, v); chk("R8 event wins", v, 32'h0000_0041);
      wr_reg(8'h30, 32'h1); idle(2);
      chk("R9 cleared", {31'b0, irq}, 0);
      @(negedge clk); pevt = 6'h20;
      @(negedge clk); pevt = 0; idle(2);
      chk("R9 backup no irq", {31'b0, irq}, 0);
      rd_reg(8'h30, v); chk("R5 backup bit16", v, 32'h0001_0040);
      wr_reg(8'h30, 32'h0001_0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr_reg(8'h00, 32'hFFFF_FFFF);
      wr_reg(8'h05, 32'hFFFF_FFFF);
      wr_reg(8'h38, 32'hFFFF_FFFF);
      rd_reg(8'h00, v); chk("R10 read 0x00", v, 0);
      rd_reg(8'h40, v); chk("R10 read 0x40", v, 0);
      rd_reg(8'h08, v); chk("R10 p0en intact", v, 0);
      rd_reg(8'h34, v); chk("R10 pen intact", v, 32'h1F);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1;
      t_reset();
      t_gpio_edges();
      t_gpio_irq();
      t_periph();
      t_unmapped();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule